// File: doc/BRIEF.md
# BCD Calendar Timekeeper with Cascaded Prescaler

This block keeps the time of day and the calendar date in packed BCD. A two-stage divider turns the RTC kernel clock into a once-per-second tick. The first stage is a coarse asynchronous divider and the second is a fine synchronous divider, and each has a programmable reload value. Each tick advances the seconds count. Carries ripple through the minutes, the 24-hour hours, the day of month, the month and the two-digit year. The weekday advances at each midnight.

A separate control block owns the bus and the write protection. It passes three write strobes and an init-mode qualifier to this block. A load of the time, the date or the prescaler reloads takes effect only while init mode is active. While init mode is active the calendar and both divider stages are frozen. When init mode is released, the dividers start again from their reload values. The calendar counts as uninitialised while its year field reads 00.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the time word is 0x000000 and the date word is 0x002101 (year 00, month 01, day 01, weekday 1). `cal_uninit` is 1.
- R2: Time word layout: seconds in bits [6:0], minutes in [14:8], hours in [21:16], and all other bits zero. Date word layout: day in [5:0], month in [12:8], weekday in [15:13], year in [23:16], and all other bits zero. All fields are packed BCD.
- R3: A time, date or prescaler write strobe is applied on the clock edge where it is sampled, but only if `init_mode` is high. A strobe with `init_mode` low changes nothing.
- R4: While `init_mode` is high, the time and date words hold their values except when a write strobe loads them.
- R5: With asynchronous reload A (`prer_wdata[22:16]`) and synchronous reload S (`prer_wdata[14:0]`), the first advance comes on the (A+1)×(S+1)-th clock edge with `init_mode` low. Later advances follow at that same period. Each exit from init mode restarts the count.
- R6: Seconds and minutes roll from 59 to 00 and carry. Hours count 00 to 23 in BCD, and the advance from 23:59:59 gives 00:00:00 and a day advance.
- R7: A day advance past day 30 of months 04, 06, 09 and 11, or past day 31 of the other non-February months, gives day 01 of the next month.
- R8: February ends at day 29 when the BCD year is divisible by 4, with year 00 counted as a leap year. In all other years it ends at day 28.
- R9: The weekday (1 = Monday to 7 = Sunday) increments at each day advance and wraps from 7 to 1.
- R10: A month advance from 12 gives month 01 and increments the year. The year wraps from 99 to 00.
- R11: `cal_uninit` is high exactly when the year field of the date word is 00.
- R12: `second_tick` is high for the single cycle whose clock edge advances the calendar, and never while `init_mode` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RTC kernel clock |
| rst | input | 1 | Synchronous active-high reset |
| init_mode | input | 1 | Init-mode qualifier from the control block |
| time_we | input | 1 | Time word write strobe |
| time_wdata | input | 24 | Time word to load (R2 layout) |
| date_we | input | 1 | Date word write strobe |
| date_wdata | input | 24 | Date word to load (R2 layout) |
| prer_we | input | 1 | Prescaler reload write strobe |
| prer_wdata | input | 23 | Synchronous reload in [14:0], asynchronous reload in [22:16] |
| time_word | output | 24 | Current time of day, packed BCD |
| date_word | output | 24 | Current date, packed BCD |
| second_tick | output | 1 | One-cycle pulse on each calendar advance |
| cal_uninit | output | 1 | Year field is 00 |

## Verification
The carry chain is tried with both reloads set to zero, so every clock edge outside init mode is one second. In that mode the bench loads states just before each boundary: a plain seconds digit carry, a minute-to-hour carry, midnight into a 30-day month end, a 31-day month mid-month, February of a leap year, a non-leap year and year 00, and the turn of the century. These cases separate the month-length table, the leap rule and the weekday and year wraps from one another. A separate run with reloads of 1 and 2 counts the edges to the first, second and post-restart advances. This catches any off-by-one in either divider stage and any failure to restart. Writes strobed outside init mode and long holds inside it are each checked against the unchanged words.

// File: rtl/bcdcal_pkg.sv
package bcdcal_pkg;

    typedef struct packed {
        logic [7:0] hr;
        logic [7:0] mn;
        logic [7:0] sc;
    } clk_time_t;

    typedef struct packed {
        logic [7:0] yr;
        logic [7:0] mo;
        logic [7:0] dy;
        logic [2:0] wd;
    } cal_date_t;

    // Two-digit BCD increment (no wrap handling; callers wrap first)
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Year divisible by four (00 counts)
    function automatic logic is_leap(input logic [7:0] yr);
        logic [6:0] bin;
        bin = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
        return bin[1:0] == 2'b00;
    endfunction

    // Last day of the month in BCD
    function automatic logic [7:0] last_day(input logic [7:0] mo, input logic [7:0] yr);
        case (mo)
            8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic logic [23:0] pack_time(input clk_time_t t);
        return {2'b00, t.hr[5:0], 1'b0, t.mn[6:0], 1'b0, t.sc[6:0]};
    endfunction

    function automatic clk_time_t unpack_time(input logic [23:0] w);
        clk_time_t t;
        t.hr = {2'b00, w[21:16]};
        t.mn = {1'b0, w[14:8]};
        t.sc = {1'b0, w[6:0]};
        return t;
    endfunction

    function automatic logic [23:0] pack_date(input cal_date_t d);
        return {d.yr, d.wd, d.mo[4:0], 2'b00, d.dy[5:0]};
    endfunction

    function automatic cal_date_t unpack_date(input logic [23:0] w);
        cal_date_t d;
        d.yr = w[23:16];
        d.wd = w[15:13];
        d.mo = {3'b000, w[12:8]};
        d.dy = {2'b00, w[5:0]};
        return d;
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
    parameter int AW     = 7,
    parameter int SW     = 15,
    parameter int A_INIT = 127,
    parameter int S_INIT = 255
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    input  logic          ld,
    input  logic [AW-1:0] ld_a,
    input  logic [SW-1:0] ld_s,
    output logic          tick
);
    logic [AW-1:0] a_rl, ac;
    logic [SW-1:0] s_rl, sc;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_rl <= AW'(A_INIT);
            s_rl <= SW'(S_INIT);
            ac   <= AW'(A_INIT);
            sc   <= SW'(S_INIT);
        end else begin
            if (ld) begin
                a_rl <= ld_a;
                s_rl <= ld_s;
            end
            if (hold) begin
                ac <= ld ? ld_a : a_rl;
                sc <= ld ? ld_s : s_rl;
            end else if (ac == '0) begin
                ac <= a_rl;
                sc <= (sc == '0) ? s_rl : sc - 1'b1;
            end else begin
                ac <= ac - 1'b1;
            end
        end
    end

    assign tick = !hold && (ac == '0) && (sc == '0);
endmodule

// File: rtl/cal_time.sv
module cal_time
    import bcdcal_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      ld,
    input  clk_time_t ld_val,
    output clk_time_t cur,
    output logic      day_adv
);
    clk_time_t nxt;
    logic      wrap;

    always_comb begin
        nxt  = cur;
        wrap = 1'b0;
        if (cur.sc == 8'h59) begin
            nxt.sc = 8'h00;
            if (cur.mn == 8'h59) begin
                nxt.mn = 8'h00;
                if (cur.hr == 8'h23) begin
                    nxt.hr = 8'h00;
                    wrap   = 1'b1;
                end else begin
                    nxt.hr = bcd_inc(cur.hr);
                end
            end else begin
                nxt.mn = bcd_inc(cur.mn);
            end
        end else begin
            nxt.sc = bcd_inc(cur.sc);
        end
    end

    assign day_adv = tick && wrap;

    always_ff @(posedge clk) begin
        if (rst)       cur <= '0;
        else if (ld)   cur <= ld_val;
        else if (tick) cur <= nxt;
    end
endmodule

// File: rtl/cal_date.sv
module cal_date
    import bcdcal_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      adv,
    input  logic      ld,
    input  cal_date_t ld_val,
    output cal_date_t cur
);
    cal_date_t nxt;

    always_comb begin
        nxt    = cur;
        nxt.wd = (cur.wd == 3'd7) ? 3'd1 : cur.wd + 3'd1;
        if (cur.dy == last_day(cur.mo, cur.yr)) begin
            nxt.dy = 8'h01;
            if (cur.mo == 8'h12) begin
                nxt.mo = 8'h01;
                nxt.yr = (cur.yr == 8'h99) ? 8'h00 : bcd_inc(cur.yr);
            end else begin
                nxt.mo = bcd_inc(cur.mo);
            end
        end else begin
            nxt.dy = bcd_inc(cur.dy);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.yr <= 8'h00;
            cur.mo <= 8'h01;
            cur.dy <= 8'h01;
            cur.wd <= 3'd1;
        end else if (ld) begin
            cur <= ld_val;
        end else if (adv) begin
            cur <= nxt;
        end
    end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import bcdcal_pkg::*;
#(
    parameter int A_BITS   = 7,
    parameter int S_BITS   = 15,
    parameter int A_RELOAD = 127,
    parameter int S_RELOAD = 255
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        init_mode,
    input  logic        time_we,
    input  logic [23:0] time_wdata,
    input  logic        date_we,
    input  logic [23:0] date_wdata,
    input  logic        prer_we,
    input  logic [22:0] prer_wdata,
    output logic [23:0] time_word,
    output logic [23:0] date_word,
    output logic        second_tick,
    output logic        cal_uninit
);
    localparam int A_LSB = 16;

    clk_time_t t_cur;
    cal_date_t d_cur;
    logic      tick, day_adv;

    cal_prescaler #(
        .AW(A_BITS), .SW(S_BITS), .A_INIT(A_RELOAD), .S_INIT(S_RELOAD)
    ) u_pre (
        .clk  (clk),
        .rst  (rst),
        .hold (init_mode),
        .ld   (prer_we && init_mode),
        .ld_a (prer_wdata[A_LSB +: A_BITS]),
        .ld_s (prer_wdata[S_BITS-1:0]),
        .tick (tick)
    );

    cal_time u_time (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .ld      (time_we && init_mode),
        .ld_val  (unpack_time(time_wdata)),
        .cur     (t_cur),
        .day_adv (day_adv)
    );

    cal_date u_date (
        .clk    (clk),
        .rst    (rst),
        .adv    (day_adv),
        .ld     (date_we && init_mode),
        .ld_val (unpack_date(date_wdata)),
        .cur    (d_cur)
    );

    assign time_word   = pack_time(t_cur);
    assign date_word   = pack_date(d_cur);
    assign second_tick = tick;
    assign cal_uninit  = (d_cur.yr == 8'h00);
endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk (
    input logic        clk,
    input logic        rst,
    input logic        init_mode,
    input logic        time_we,
    input logic        date_we,
    input logic        second_tick,
    input logic [23:0] time_word,
    input logic [23:0] date_word
);
    // R4
    init_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (init_mode && !time_we && !date_we) |=> ($stable(time_word) && $stable(date_word)));

    // R3
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!init_mode && !second_tick) |=> ($stable(time_word) && $stable(date_word)));

    // R12
    tick_advances_chk: assert property (@(posedge clk) disable iff (rst)
        second_tick |=> !$stable(time_word));

    // R12
    tick_not_in_init_chk: assert property (@(posedge clk) disable iff (rst)
        init_mode |-> !second_tick);

    // R6
    date_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (second_tick && time_word != 24'h235959) |=> $stable(date_word));

    // R9
    weekday_step_chk: assert property (@(posedge clk) disable iff (rst)
        (second_tick && time_word == 24'h235959) |=> !$stable(date_word[15:13]));
endmodule

bind bcd_calendar bcd_calendar_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .init_mode   (init_mode),
    .time_we     (time_we),
    .date_we     (date_we),
    .second_tick (second_tick),
    .time_word   (time_word),
    .date_word   (date_word)
);

// File: tb/sim_bcd_calendar.sv
`timescale 1ns/1ps
module sim_bcd_calendar;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        init_mode = 1'b0;
    logic        time_we = 1'b0, date_we = 1'b0, prer_we = 1'b0;
    logic [23:0] time_wdata = '0, date_wdata = '0;
    logic [22:0] prer_wdata = '0;
    logic [23:0] time_word, date_word;
    logic        second_tick, cal_uninit;
    int          total = 0, bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    bcd_calendar u0 (.*);

    task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // load all three registers in init mode; init stays high afterwards
    task automatic load(input logic [23:0] t, input logic [23:0] d,
                        input logic [6:0] a, input logic [14:0] s);
        @(negedge clk);
        init_mode = 1'b1;
        time_we = 1'b1; date_we = 1'b1; prer_we = 1'b1;
        time_wdata = t; date_wdata = d;
        prer_wdata = {a, 1'b0, s};
        @(negedge clk);
        time_we = 1'b0; date_we = 1'b0; prer_we = 1'b0;
    endtask

    // leave init for k edges, then re-enter
    task automatic run(input int k);
        init_mode = 1'b0;
        repeat (k) @(negedge clk);
        init_mode = 1'b1;
    endtask

    task automatic t_reset;
        chk("R1 time", time_word, 24'h000000);
        chk("R1 date", date_word, 24'h002101);
        chk("R1 uninit", {23'd0, cal_uninit}, 24'd1);
        chk("R12 tick low", {23'd0, second_tick}, 24'd0);
    endtask

    task automatic t_digits;
        load(24'h123409, 24'h052101, 7'd0, 15'd0);
        run(1);
        chk("R2 R6 digit carry", time_word, 24'h123410);
        chk("R11 year 05", {23'd0, cal_uninit}, 24'd0);
        load(24'h095959, 24'h052101, 7'd0, 15'd0);
        run(1);
        chk("R6 hour carry", time_word, 24'h100000);
        chk("R6 date held", date_word, 24'h052101);
    endtask

    task automatic t_leap;
        load(24'h235958, 24'h24E228, 7'd0, 15'd0);
        run(2);
        chk("R6 midnight", time_word, 24'h000000);
        chk("R8 R9 leap feb29", date_word, 24'h242229);
        load(24'h235959, 24'h236228, 7'd0, 15'd0);
        run(1);
        chk("R8 nonleap mar1", date_word, 24'h238301);
        load(24'h235959, 24'h002228, 7'd0, 15'd0);
        run(1);
        chk("R8 year00 leap", date_word, 24'h004229);
        chk("R11 year00", {23'd0, cal_uninit}, 24'd1);
    endtask

    task automatic t_months;
        load(24'h235959, 24'h21A430, 7'd0, 15'd0);
        run(1);
        chk("R7 april end", date_word, 24'h21C501);
        load(24'h235959, 24'h214130, 7'd0, 15'd0);
        run(1);
        chk("R7 jan 31", date_word, 24'h216131);
        load(24'h235959, 24'h99D231, 7'd0, 15'd0);
        run(1);
        chk("R10 R9 century", date_word, 24'h00E101);
        chk("R10 time", time_word, 24'h000000);
    endtask

    task automatic t_gate;
        load(24'h010203, 24'h052101, 7'd3, 15'd3);
        init_mode = 1'b0;
        time_we = 1'b1; date_we = 1'b1;
        time_wdata = 24'h112233; date_wdata = 24'h104315;
        @(negedge clk);
        time_we = 1'b0; date_we = 1'b0;
        @(negedge clk);
        chk("R3 ignored time", time_word, 24'h010203);
        chk("R3 ignored date", date_word, 24'h052101);
        init_mode = 1'b1;
        load(24'h010203, 24'h052101, 7'd0, 15'd0);
        repeat (20) @(negedge clk);
        chk("R4 frozen time", time_word, 24'h010203);
        chk("R12 no tick in init", {23'd0, second_tick}, 24'd0);
    endtask

    task automatic t_period;
        load(24'h000000, 24'h052101, 7'd1, 15'd2);   // period 6
        init_mode = 1'b0;
        repeat (4) @(negedge clk);
        chk("R12 no early tick", {23'd0, second_tick}, 24'd0);
        @(negedge clk);
        chk("R5 before 6", time_word, 24'h000000);
        chk("R12 tick high", {23'd0, second_tick}, 24'd1);
        @(negedge clk);
        chk("R5 at 6", time_word, 24'h000001);
        chk("R12 tick single", {23'd0, second_tick}, 24'd0);
        repeat (6) @(negedge clk);
        chk("R5 at 12", time_word, 24'h000002);
        repeat (2) @(negedge clk);
        init_mode = 1'b1;
        @(negedge clk);
        init_mode = 1'b0;
        repeat (5) @(negedge clk);
        chk("R5 restart not early", time_word, 24'h000002);
        @(negedge clk);
        chk("R5 restart period", time_word, 24'h000003);
        init_mode = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_digits();
        t_leap();
        t_months();
        t_gate();
        t_period();
        done = 1'b1;
    end

    initial begin : watchdog
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule